// File: doc/BRIEF.md
# Platform System Control Port Block

This block is a byte-wide register file that sits on a legacy I/O port bus. A single access strobe carries a write flag, a 16-bit port number and a write byte. The block decodes one combined soft-reset/endianness port and a bank of control and status ports around port 0x800. It answers reads with fixed identification and feature bytes or with its stored control state. Write side effects drive a reset request line, a little-endian mode flag, a status-light output and two single-cycle lock-toggle pulses for an NVRAM device.

The block also owns the I/O map mode bit. That bit picks how an offset inside the CPU-side I/O window becomes a 16-bit port address. In flat mode the offset is masked to 64 KB. In sparse mode, offset bits [22:12] are packed directly above offset bits [4:0]. The translated address is combinational and is presented on its own output for the downstream port bus.

Top module: `syscp_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), reset_req, le_mode, light_on and map_sparse are 0, the stored system control nibble is 0, rd_data is 0x00 and rd_valid is 0.
- R2: A write to port 0x092 sets reset_req from data bit 0 and le_mode from data bit 1 at the next clock edge. A read of 0x092 returns le_mode in bit 1 and zero in every other bit.
- R3: Ports 0x800, 0x802 and 0x803 read 0xEF, 0xAD and 0xE0. Writes to them change no output and no readable value.
- R4: Ports 0x80C, 0x810, 0x818 and 0x823 read 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to port 0x808 sets light_on from data bit 0 at the next clock edge.
- R6: lock_pulse_a is high exactly during a cycle that carries an accepted write to 0x810. lock_pulse_b is high exactly during a cycle that carries an accepted write to 0x812. Neither is high at any other time.
- R7: A write to port 0x81C stores data bits [3:0] and drops bits [7:4]. A read of 0x81C returns the stored nibble with bits [7:4] zero.
- R8: A write to port 0x850 sets map_sparse from data bit 0. A read of 0x850 returns map_sparse in bit 0 and zero elsewhere.
- R9: A read of port 0x814, or of any port other than those named in R2 to R8, returns 0xFF. A write to such a port changes no output and no readable value.
- R10: While map_sparse is 0, port_addr equals win_offset[15:0].
- R11: While map_sparse is 1, port_addr[4:0] equals win_offset[4:0] and port_addr[15:5] equals win_offset[22:12].
- R12: Read data appears on rd_data in the cycle after a read strobe, with rd_valid high for that one cycle. rd_data holds its value when there is no read. A cycle with bus_valid low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Port number of the access |
| bus_wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High in the cycle rd_data carries a new read result |
| reset_req | output | 1 | Soft reset request |
| le_mode | output | 1 | Little-endian mode flag |
| light_on | output | 1 | Status light |
| lock_pulse_a | output | 1 | First NVRAM lock toggle pulse |
| lock_pulse_b | output | 1 | Second NVRAM lock toggle pulse |
| map_sparse | output | 1 | I/O map mode, 1 = sparse 8 MB window |
| win_offset | input | 23 | Offset inside the CPU-side I/O window |
| port_addr | output | 16 | Translated 16-bit port address |

## Verification
The assertions assume that a strobe carries a known address and write flag whenever bus_valid is high, and that win_offset is driven to a known value in every cycle. They also assume that reset is held for at least one clock edge before the first access. The stimulus changes inputs only just after a rising edge. It keeps win_offset always defined and holds rst_n low for several edges before it starts. It sweeps writes of all-ones and mixed patterns to every named port, to neighbours just outside the decoded range, and to holes inside the range. Each write is followed by reads that bring out any state the write could have disturbed.

// File: rtl/syscp_pkg.sv
// Package: shared constants and the port-select type for the system control
// port block. Assumes an 8-bit data bus and a 16-bit port space.
package syscp_pkg;

    localparam int PORT_W = 16;
    localparam int DATA_W = 8;

    // Decoded port numbers
    localparam logic [PORT_W-1:0] P_RST_END  = 16'h0092;
    localparam logic [PORT_W-1:0] P_ID_CPU   = 16'h0800;
    localparam logic [PORT_W-1:0] P_ID_FEAT  = 16'h0802;
    localparam logic [PORT_W-1:0] P_ID_STAT  = 16'h0803;
    localparam logic [PORT_W-1:0] P_LIGHT    = 16'h0808;
    localparam logic [PORT_W-1:0] P_EQUIP    = 16'h080C;
    localparam logic [PORT_W-1:0] P_LOCK_A   = 16'h0810;
    localparam logic [PORT_W-1:0] P_LOCK_B   = 16'h0812;
    localparam logic [PORT_W-1:0] P_CACHEINV = 16'h0814;
    localparam logic [PORT_W-1:0] P_KEY      = 16'h0818;
    localparam logic [PORT_W-1:0] P_SYSCTL   = 16'h081C;
    localparam logic [PORT_W-1:0] P_L2INFO   = 16'h0823;
    localparam logic [PORT_W-1:0] P_MAPMODE  = 16'h0850;
    localparam logic [PORT_W-1:0] P_BANK_LO  = 16'h0800;
    localparam logic [PORT_W-1:0] P_BANK_HI  = 16'h0851;

    // Fixed read values
    localparam logic [DATA_W-1:0] V_ID_CPU  = 8'hEF;
    localparam logic [DATA_W-1:0] V_ID_FEAT = 8'hAD;
    localparam logic [DATA_W-1:0] V_ID_STAT = 8'hE0;
    localparam logic [DATA_W-1:0] V_EQUIP   = 8'h3C;
    localparam logic [DATA_W-1:0] V_EXTFEAT = 8'h39;
    localparam logic [DATA_W-1:0] V_KEY     = 8'h00;
    localparam logic [DATA_W-1:0] V_L2INFO  = 8'h03;
    localparam logic [DATA_W-1:0] V_EMPTY   = 8'hFF;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_RST_END,
        SEL_ID_CPU,
        SEL_ID_FEAT,
        SEL_ID_STAT,
        SEL_LIGHT,
        SEL_EQUIP,
        SEL_LOCK_A,
        SEL_LOCK_B,
        SEL_CACHEINV,
        SEL_KEY,
        SEL_SYSCTL,
        SEL_L2INFO,
        SEL_MAPMODE
    } port_sel_e;

endpackage

// File: rtl/syscp_decode.sv
// Module: syscp_decode
// Maps a port number onto a port-select code. Pure combinational logic.
// Assumes the address is known whenever the strobe is valid. Ports outside
// the decoded window, and holes inside it, map to SEL_NONE.
module syscp_decode
    import syscp_pkg::*;
#(
    parameter int AW = PORT_W
) (
    input  logic [AW-1:0] addr,
    output port_sel_e     sel
);

    logic in_bank;

    // Range check for the bank of control ports
    always_comb begin
        in_bank = (addr >= AW'(P_BANK_LO)) && (addr <= AW'(P_BANK_HI));
    end

    // Exact match of the named ports
    always_comb begin
        sel = SEL_NONE;
        if (addr == AW'(P_RST_END)) begin
            sel = SEL_RST_END;
        end else if (in_bank) begin
            case (addr)
                AW'(P_ID_CPU):   sel = SEL_ID_CPU;
                AW'(P_ID_FEAT):  sel = SEL_ID_FEAT;
                AW'(P_ID_STAT):  sel = SEL_ID_STAT;
                AW'(P_LIGHT):    sel = SEL_LIGHT;
                AW'(P_EQUIP):    sel = SEL_EQUIP;
                AW'(P_LOCK_A):   sel = SEL_LOCK_A;
                AW'(P_LOCK_B):   sel = SEL_LOCK_B;
                AW'(P_CACHEINV): sel = SEL_CACHEINV;
                AW'(P_KEY):      sel = SEL_KEY;
                AW'(P_SYSCTL):   sel = SEL_SYSCTL;
                AW'(P_L2INFO):   sel = SEL_L2INFO;
                AW'(P_MAPMODE):  sel = SEL_MAPMODE;
                default:         sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/syscp_regs.sv
// Module: syscp_regs
// Holds the writable control state, builds the registered read data and
// forms the lock pulses. Assumes one access per cycle and a synchronous
// active-low reset.
module syscp_regs
    import syscp_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int SCTL_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          write,
    input  port_sel_e     sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          reset_req,
    output logic          le_mode,
    output logic          light_on,
    output logic          map_sparse,
    output logic          lock_a,
    output logic          lock_b
);

    localparam int PAD_W = DW - SCTL_W;

    logic              wr_en;
    logic              rd_en;
    logic [SCTL_W-1:0] sysctl_q;
    logic [DW-1:0]     rd_next;

    // Split the strobe into read and write enables
    always_comb begin
        wr_en = strobe && write;
        rd_en = strobe && !write;
    end

    // Lock pulses follow the accepted write in the same cycle
    always_comb begin
        lock_a = wr_en && (sel == SEL_LOCK_A);
        lock_b = wr_en && (sel == SEL_LOCK_B);
    end

    // Reset and endian controls, both written through the shared port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
            le_mode   <= 1'b0;
        end else if (wr_en && sel == SEL_RST_END) begin
            reset_req <= wdata[0];
            le_mode   <= wdata[1];
        end
    end

    // Status light
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            light_on <= 1'b0;
        end else if (wr_en && sel == SEL_LIGHT) begin
            light_on <= wdata[0];
        end
    end

    // System control nibble, upper data bits dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sysctl_q <= '0;
        end else if (wr_en && sel == SEL_SYSCTL) begin
            sysctl_q <= wdata[SCTL_W-1:0];
        end
    end

    // I/O map mode bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_sparse <= 1'b0;
        end else if (wr_en && sel == SEL_MAPMODE) begin
            map_sparse <= wdata[0];
        end
    end

    // Read multiplexer over fixed bytes and stored state
    always_comb begin
        case (sel)
            SEL_RST_END: rd_next = DW'({le_mode, 1'b0});
            SEL_ID_CPU:  rd_next = V_ID_CPU;
            SEL_ID_FEAT: rd_next = V_ID_FEAT;
            SEL_ID_STAT: rd_next = V_ID_STAT;
            SEL_EQUIP:   rd_next = V_EQUIP;
            SEL_LOCK_A:  rd_next = V_EXTFEAT;
            SEL_KEY:     rd_next = V_KEY;
            SEL_SYSCTL:  rd_next = {{PAD_W{1'b0}}, sysctl_q};
            SEL_L2INFO:  rd_next = V_L2INFO;
            SEL_MAPMODE: rd_next = DW'(map_sparse);
            default:     rd_next = V_EMPTY;
        endcase
    end

    // Registered read result, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_next;
            end
        end
    end

endmodule

// File: rtl/syscp_xlate.sv
// Module: syscp_xlate
// Translates a CPU-side I/O window offset into a port address. Flat mode
// keeps the low port bits. Sparse mode packs a high bit field directly above
// a low bit field. Assumes WIN_W covers the high field.
module syscp_xlate #(
    parameter int WIN_W  = 23,
    parameter int PW     = 16,
    parameter int LO_W   = 5,
    parameter int HI_LSB = 12
) (
    input  logic [WIN_W-1:0] offset,
    input  logic             sparse,
    output logic [PW-1:0]    port
);

    localparam int HI_W   = PW - LO_W;
    localparam int HI_MSB = HI_LSB + HI_W - 1;

    logic [PW-1:0] flat_addr;
    logic [PW-1:0] sparse_addr;

    generate
        if (HI_MSB < WIN_W && PW <= WIN_W) begin : g_fit
            // Both address forms taken from the offset
            always_comb begin
                flat_addr   = offset[PW-1:0];
                sparse_addr = {offset[HI_MSB:HI_LSB], offset[LO_W-1:0]};
            end
        end else begin : g_short
            logic [HI_MSB:0] wide;
            // Zero-extend a narrow window before slicing
            always_comb begin
                wide        = (HI_MSB+1)'(offset);
                flat_addr   = wide[PW-1:0];
                sparse_addr = {wide[HI_MSB:HI_LSB], wide[LO_W-1:0]};
            end
        end
    endgenerate

    // Select the form given by the map mode
    always_comb begin
        port = sparse ? sparse_addr : flat_addr;
    end

endmodule

// File: rtl/syscp_top.sv
// Module: syscp_top
// System control port block: decode, control registers and I/O window
// translation. Assumes one byte access per cycle, with read data one cycle
// after the strobe and a synchronous active-low reset.
module syscp_top
    import syscp_pkg::*;
#(
    parameter int AW     = PORT_W,
    parameter int DW     = DATA_W,
    parameter int WIN_W  = 23,
    parameter int SCTL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             reset_req,
    output logic             le_mode,
    output logic             light_on,
    output logic             lock_pulse_a,
    output logic             lock_pulse_b,
    output logic             map_sparse,
    input  logic [WIN_W-1:0] win_offset,
    output logic [AW-1:0]    port_addr
);

    port_sel_e sel;

    syscp_decode #(.AW(AW)) i_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    syscp_regs #(.DW(DW), .SCTL_W(SCTL_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (bus_valid),
        .write      (bus_write),
        .sel        (sel),
        .wdata      (bus_wdata),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .reset_req  (reset_req),
        .le_mode    (le_mode),
        .light_on   (light_on),
        .map_sparse (map_sparse),
        .lock_a     (lock_pulse_a),
        .lock_b     (lock_pulse_b)
    );

    syscp_xlate #(.WIN_W(WIN_W), .PW(AW)) i_xlate (
        .offset (win_offset),
        .sparse (map_sparse),
        .port   (port_addr)
    );

endmodule

// File: rtl/syscp_checker.sv
// Module: syscp_checker
// Port-level properties of the system control port block, bound to the top.
module syscp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  rd_data,
    input logic        rd_valid,
    input logic        reset_req,
    input logic        le_mode,
    input logic        light_on,
    input logic        lock_pulse_a,
    input logic        lock_pulse_b,
    input logic        map_sparse,
    input logic [22:0] win_offset,
    input logic [15:0] port_addr
);

    AST_RST_END_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 16'h0092) |=> (reset_req == $past(bus_wdata[0]) && le_mode == $past(bus_wdata[1]))); // R2

    AST_ID_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 16'h0800) |=> (rd_data == 8'hEF)); // R3

    AST_EQUIP_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 16'h080C) |=> (rd_data == 8'h3C)); // R4

    AST_LIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_addr == 16'h0808) |=> $stable(light_on)); // R5

    AST_LOCK_A_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_pulse_a |-> (bus_valid && bus_write && bus_addr == 16'h0810)); // R6

    AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lock_pulse_a, lock_pulse_b})); // R6

    AST_SYSCTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 16'h081C) |=> (rd_data[7:4] == 4'h0)); // R7

    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_addr == 16'h0850) |=> $stable(map_sparse)); // R8

    AST_HOLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 16'h0814) |=> (rd_data == 8'hFF)); // R9

    AST_XLATE_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        !map_sparse |-> (port_addr == win_offset[15:0])); // R10

    AST_XLATE_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
        map_sparse |-> (port_addr[4:0] == win_offset[4:0] && port_addr[15:5] == win_offset[22:12])); // R11

    AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid); // R12

    AST_RD_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == $past(rd_data) || $past(!rst_n))); // R12

endmodule

bind syscp_top syscp_checker i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .reset_req    (reset_req),
    .le_mode      (le_mode),
    .light_on     (light_on),
    .lock_pulse_a (lock_pulse_a),
    .lock_pulse_b (lock_pulse_b),
    .map_sparse   (map_sparse),
    .win_offset   (win_offset),
    .port_addr    (port_addr)
);

// File: tb/test_syscp_top.sv
// Bench: behavioural reference model of the port block, compared on every
// falling clock edge against all outputs.
module test_syscp_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [22:0] win_offset = '0;
    logic [7:0]  rd_data;
    logic        rd_valid, reset_req, le_mode, light_on;
    logic        lock_pulse_a, lock_pulse_b, map_sparse;
    logic [15:0] port_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;

    // Reference state
    int    m_rst, m_le, m_light, m_map, m_sysctl, m_rdata, m_rdv;
    string m_rtag = "R1";
    bit    m_in_reset = 1;

    always #4 clk = ~clk;

    syscp_top i_syscp_top (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .reset_req(reset_req), .le_mode(le_mode),
        .light_on(light_on), .lock_pulse_a(lock_pulse_a),
        .lock_pulse_b(lock_pulse_b), .map_sparse(map_sparse),
        .win_offset(win_offset), .port_addr(port_addr)
    );

    function automatic int ref_read(int a);
        case (a)
            'h092: return m_le * 2;
            'h800: return 'hEF;
            'h802: return 'hAD;
            'h803: return 'hE0;
            'h80C: return 'h3C;
            'h810: return 'h39;
            'h818: return 'h00;
            'h81C: return m_sysctl;
            'h823: return 'h03;
            'h850: return m_map;
            default: return 'hFF;
        endcase
    endfunction

    function automatic string read_tag(int a);
        case (a)
            'h092: return "R2";
            'h800, 'h802, 'h803: return "R3";
            'h80C, 'h810, 'h818, 'h823: return "R4";
            'h81C: return "R7";
            'h850: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Model update on each rising edge from the inputs held in that cycle
    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (!rst_n) begin
            m_rst = 0; m_le = 0; m_light = 0; m_map = 0; m_sysctl = 0;
            m_rdata = 0; m_rdv = 0; m_rtag = "R1"; m_in_reset = 1;
        end else begin
            m_in_reset = 0;
            m_rdv = 0;
            if (bus_valid && !bus_write) begin
                m_rdata = ref_read(int'(bus_addr));
                m_rdv = 1;
                m_rtag = read_tag(int'(bus_addr));
            end else if (bus_valid && bus_write) begin
                case (int'(bus_addr))
                    'h092: begin m_rst = bus_wdata[0]; m_le = bus_wdata[1]; end
                    'h808: m_light = bus_wdata[0];
                    'h81C: m_sysctl = bus_wdata % 16;
                    'h850: m_map = bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            int exp_port;
            string t;
            t = m_in_reset ? "R1" : "R2";
            check(t, "reset_req", int'(reset_req), m_rst);
            check(t, "le_mode", int'(le_mode), m_le);
            check(m_in_reset ? "R1" : "R5", "light_on", int'(light_on), m_light);
            check(m_in_reset ? "R1" : "R8", "map_sparse", int'(map_sparse), m_map);
            check(m_in_reset ? "R1" : "R12", "rd_valid", int'(rd_valid), m_rdv);
            check(m_in_reset ? "R1" : m_rtag, "rd_data", int'(rd_data), m_rdata);
            check("R6", "lock_pulse_a", int'(lock_pulse_a),
                  int'(bus_valid && bus_write && bus_addr == 16'h0810));
            check("R6", "lock_pulse_b", int'(lock_pulse_b),
                  int'(bus_valid && bus_write && bus_addr == 16'h0812));
            if (m_map != 0) begin
                exp_port = (int'(win_offset) & 'h1F) | ((int'(win_offset) & 'h7FF000) >> 7);
                check("R11", "port_addr", int'(port_addr), exp_port);
            end else begin
                exp_port = int'(win_offset) & 'hFFFF;
                check("R10", "port_addr", int'(port_addr), exp_port);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [15:0] a);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_wdata = 8'h5A;
        step();
        bus_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic read_all();
        rd(16'h0092); rd(16'h0800); rd(16'h0802); rd(16'h0803);
        rd(16'h080C); rd(16'h0810); rd(16'h0818); rd(16'h081C);
        rd(16'h0823); rd(16'h0850); rd(16'h0814); rd(16'h0808);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R12 watchdog: actual %0d expected %0d", cycles, 0);
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        win_offset = 23'h012345;
        idle(4);
        rst_n = 1;
        step();
        // R1: readback after reset
        read_all();
        // R2: reset and endian port
        wr(16'h0092, 8'h03); rd(16'h0092);
        wr(16'h0092, 8'hFE); rd(16'h0092);
        wr(16'h0092, 8'h00); rd(16'h0092);
        wr(16'h0092, 8'h01); idle(2);
        // R3: id ports ignore writes
        wr(16'h0800, 8'h00); wr(16'h0802, 8'h11); wr(16'h0803, 8'hFF);
        read_all();
        // R5: light
        wr(16'h0808, 8'hFF); idle(1); wr(16'h0808, 8'hFE); wr(16'h0808, 8'h01);
        // R6: lock pulses, including back to back and a strobe-less cycle
        wr(16'h0810, 8'h00); wr(16'h0812, 8'hFF); wr(16'h0810, 8'h55);
        bus_addr = 16'h0812; bus_write = 1; step(); bus_write = 0;
        // R7: system control nibble
        wr(16'h081C, 8'hFF); rd(16'h081C);
        wr(16'h081C, 8'hA5); rd(16'h081C);
        // R9: holes and outside ports
        wr(16'h0814, 8'hFF); wr(16'h0801, 8'hFF); wr(16'h0852, 8'h01);
        wr(16'h0091, 8'hFF); wr(16'h0093, 8'h02); wr(16'h1850, 8'h01);
        wr(16'h0851, 8'hFF); wr(16'h07FF, 8'h01);
        read_all();
        rd(16'h0851); rd(16'h0852); rd(16'h0000); rd(16'hFFFF); rd(16'h0812);
        // R10: flat translation patterns
        win_offset = 23'h7FFFFF; step();
        win_offset = 23'h00ABCD; step();
        win_offset = 23'h5A5A5A; step();
        // R8 / R11: sparse mode
        wr(16'h0850, 8'hFF); rd(16'h0850);
        win_offset = 23'h7FF01F; step();
        win_offset = 23'h001000; step();
        win_offset = 23'h400FE0; step();
        win_offset = 23'h2AA015; step();
        win_offset = 23'h7FFFFF; step();
        wr(16'h0850, 8'hFE); rd(16'h0850);
        win_offset = 23'h123456; step();
        // R12: hold between reads, and valid-low cycles
        rd(16'h0800); idle(3);
        bus_addr = 16'h081C; bus_wdata = 8'h0F; bus_write = 1; step(); bus_write = 0;
        rd(16'h081C);
        // R1: second reset clears everything
        wr(16'h0850, 8'h01); wr(16'h0808, 8'h01); wr(16'h0092, 8'h03);
        rst_n = 0; idle(2); rst_n = 1; step();
        read_all();
        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule